// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block takes configuration writes from a slow three-wire serial link (a serial clock, an active-low enable and a data line) and stores them in a bank of sixteen 12-bit registers. It runs on a fast system clock. The three serial lines are synchronised into that clock domain. Falling edges of the serial clock are detected from the synchronised samples, and the data line is sampled at those edges.

While the enable is low, every detected falling edge shifts one bit into a 16-bit word. Each word arrives most significant bit first. The upper four bits of the word select the register and the lower twelve bits are its new value. After every sixteenth bit the word is committed. The block then pulses a one-cycle write strobe, presents the address and data with it, and updates the addressed register.

Any number of words may follow one another in a single enable window. Bits left over when the enable rises are dropped. The system clock must run at least four times faster than the serial clock.

Top module: `ser_cfg_loader`

## Requirements
- R1: After the asynchronous active-low reset, all sixteen registers read zero and the write strobe is low.
- R2: Bits shift in only while the enable is low. Serial clock falling edges seen while the enable is high cause no write and do not advance the bit count, so the next word after the enable falls is received intact.
- R3: The data line is sampled on serial clock falling edges, most significant bit first. Word bits 15..12 form the address and bits 11..0 form the data.
- R4: On each sixteenth falling edge of an enable window, the write strobe is high for exactly one system clock cycle. In that cycle the address and data outputs hold the received word, and the addressed register holds the new data.
- R5: Several words sent back to back within one enable window are each written, in order, with one strobe per word.
- R6: Bits left over when the enable rises after a count that is not a multiple of sixteen produce no write. The next enable window starts counting from zero.
- R7: Registers other than the addressed one, and all registers when no strobe is issued, keep their values.
- R8: Two write strobes are never high in consecutive system clock cycles, and the number of strobes equals the number of complete words received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock, asynchronous to clk |
| senNIn | input | 1 | Serial enable, active low |
| sdataIn | input | 1 | Serial data |
| wrStrobe | output | 1 | One-cycle pulse per committed word |
| wrAddr | output | 4 | Address of the committed word |
| wrData | output | 12 | Data of the committed word |
| regFile | output | 192 | All registers; register i occupies bits i*12+11 down to i*12 |

## Verification
The bench builds the block with its default parameters: a 4-bit address, 12-bit data and two synchroniser stages. With these values all sixteen registers are small enough to write in one continuous burst, and then again one word per enable window, with data computed arithmetically from the address.

The same setting makes the framing cases cheap to cover. These are serial clock toggling while the enable is high, a trailing partial word of several lengths, and a fresh window after a partial one. Each of them is checked against a bench model of the full register bank.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
  typedef struct packed {
    logic shiftEn;
    logic commit;
    logic clear;
  } ctlStrobe_t;
endpackage

// File: rtl/ser_cfg_ctrl.sv
module ser_cfg_ctrl
  import ser_cfg_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       senNIn,
  input  logic       sdataIn,
  output ctlStrobe_t ctl,
  output logic       bitOut
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [SYNC_STAGES-1:0] sclkSync, senSync, dataSync;
  logic sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic sclkS, senS, fallEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '1;
      senSync  <= '1;
      dataSync <= '0;
      sclkPrev <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkIn};
      senSync  <= {senSync[SYNC_STAGES-2:0], senNIn};
      dataSync <= {dataSync[SYNC_STAGES-2:0], sdataIn};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
    end
  end

  assign sclkS    = sclkSync[SYNC_STAGES-1];
  assign senS     = senSync[SYNC_STAGES-1];
  assign bitOut   = dataSync[SYNC_STAGES-1];
  assign fallEdge = sclkPrev & ~sclkS;

  always_comb begin
    ctl.clear   = senS;
    ctl.shiftEn = fallEdge & ~senS;
    ctl.commit  = ctl.shiftEn & (bitCnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bitCnt <= '0;
    else if (ctl.clear)    bitCnt <= '0;
    else if (ctl.commit)   bitCnt <= '0;
    else if (ctl.shiftEn)  bitCnt <= bitCnt + 1'b1;
  end

  // R2: an idle enable holds the counter at zero
  p_idle_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    senS |=> (bitCnt == '0));
  // R6: no commit can come from an idle enable
  p_no_idle_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    senS |-> !ctl.commit);
  // R4: a commit starts the next word from zero
  p_commit_wraps_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> (bitCnt == '0));
endmodule

// File: rtl/ser_cfg_dp.sv
module ser_cfg_dp
  import ser_cfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctlStrobe_t                        ctl,
  input  logic                              bitIn,
  output logic                              wrStrobe,
  output logic [ADDR_W-1:0]                 wrAddr,
  output logic [DATA_W-1:0]                 wrData,
  output logic [(1<<ADDR_W)*DATA_W-1:0]     regFile
);
  localparam int WORD_W   = ADDR_W + DATA_W;
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [WORD_W-2:0] shiftReg;
  logic [WORD_W-1:0] wordNext;
  logic [DATA_W-1:0] bank [NUM_REGS];

  assign wordNext = {shiftReg, bitIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (ctl.clear)      shiftReg <= '0;
    else if (ctl.shiftEn)    shiftReg <= wordNext[WORD_W-2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else begin
      wrStrobe <= ctl.commit;
      if (ctl.commit) begin
        wrAddr <= wordNext[WORD_W-1 -: ADDR_W];
        wrData <= wordNext[DATA_W-1:0];
        bank[wordNext[WORD_W-1 -: ADDR_W]] <= wordNext[DATA_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regFile[g*DATA_W +: DATA_W] = bank[g];
  end

  // R8: strobes never fall on back-to-back cycles
  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);
  // R4: the register named by the strobe holds the strobe data
  p_bank_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (bank[wrAddr] == wrData));
  // R7: without a strobe the bank does not move
  p_bank_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> $stable(regFile));
endmodule

// File: rtl/ser_cfg_loader.sv
module ser_cfg_loader
  import ser_cfg_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sclkIn,
  input  logic                          senNIn,
  input  logic                          sdataIn,
  output logic                          wrStrobe,
  output logic [ADDR_W-1:0]             wrAddr,
  output logic [DATA_W-1:0]             wrData,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regFile
);
  localparam int WORD_W = ADDR_W + DATA_W;

  ctlStrobe_t ctl;
  logic       bitS;

  ser_cfg_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .senNIn(senNIn),
    .sdataIn(sdataIn), .ctl(ctl), .bitOut(bitS)
  );

  ser_cfg_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitIn(bitS),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData), .regFile(regFile)
  );
endmodule

// File: tb/ser_cfg_loader_tb.sv
`timescale 1ns/1ps
module ser_cfg_loader_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b1, senNIn = 1'b1, sdataIn = 1'b0;
  logic wrStrobe;
  logic [3:0] wrAddr;
  logic [11:0] wrData;
  logic [191:0] regFile;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [11:0] model [16];
  int nStr = 0;
  logic [3:0]  logA [64];
  logic [11:0] logD [64];

  always #2.5 clk = ~clk;

  ser_cfg_loader u_dut (.clk(clk), .rstN(rstN), .sclkIn(sclkIn), .senNIn(senNIn),
    .sdataIn(sdataIn), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .regFile(regFile));

  always @(negedge clk) if (rstN && wrStrobe) begin
    if (nStr < 64) begin logA[nStr] = wrAddr; logD[nStr] = wrData; end
    nStr++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clockBit(input logic b);
    sclkIn = 1'b1; sdataIn = b; waitClk(6);
    sclkIn = 1'b0; waitClk(6);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clockBit(v[i]);
  endtask

  task automatic sendWord(input logic [3:0] a, input logic [11:0] d);
    sendBits({16'h0, a, d}, 16);
  endtask

  task automatic senLow;  senNIn = 1'b0; waitClk(4); endtask
  task automatic senHigh; sclkIn = 1'b1; waitClk(4); senNIn = 1'b1; waitClk(10); endtask

  task automatic checkBank(input string tag);
    for (int i = 0; i < 16; i++)
      check(regFile[i*12 +: 12] == model[i], tag, regFile[i*12 +: 12], model[i]);
  endtask

  function automatic logic [11:0] pat(input int a, input int k);
    return 12'((a * 337 + k * 1171 + 12'h5A3) & 12'hFFF);
  endfunction

  initial begin
    #750000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    for (int i = 0; i < 16; i++) model[i] = '0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    // R1 reset state
    check(wrStrobe == 1'b0, "R1 strobe", wrStrobe, 0);
    checkBank("R1 reset bank");

    // R5 burst of all sixteen addresses in one window
    base = nStr;
    senLow();
    for (int a = 0; a < 16; a++) begin sendWord(4'(a), pat(a, 1)); model[a] = pat(a, 1); end
    senHigh();
    check(nStr - base == 16, "R5/R8 strobe count", nStr - base, 16);
    for (int a = 0; a < 16; a++) begin
      check(logA[base+a] == 4'(a), "R3 addr", logA[base+a], a);
      check(logD[base+a] == pat(a, 1), "R4 data", logD[base+a], pat(a, 1));
    end
    checkBank("R4 bank after burst");

    // R2 serial clock edges while enable high
    base = nStr;
    for (int i = 0; i < 11; i++) clockBit(1'b1);
    waitClk(10);
    check(nStr == base, "R2 idle edges", nStr - base, 0);
    checkBank("R2 bank unchanged");
    senLow(); sendWord(4'd9, 12'h6C1); model[9] = 12'h6C1; senHigh();
    check(nStr - base == 1, "R2 word after idle", nStr - base, 1);
    checkBank("R2 bank after word");

    // R7 one word per window, descending addresses
    for (int k = 0; k < 16; k++) begin
      base = nStr;
      senLow(); sendWord(4'(15 - k), pat(15 - k, 2)); senHigh();
      model[15 - k] = pat(15 - k, 2);
      check(nStr - base == 1, "R8 single count", nStr - base, 1);
      check(logA[base] == 4'(15 - k), "R3 single addr", logA[base], 15 - k);
      checkBank("R7 bank single");
    end

    // R6 trailing partial words of several lengths
    for (int n = 1; n < 16; n += 3) begin
      base = nStr;
      senLow(); sendWord(4'd3, 12'(n * 99)); sendBits(32'hFFFF_FFFF, n); senHigh();
      model[3] = 12'(n * 99);
      check(nStr - base == 1, "R6 partial dropped", nStr - base, 1);
      checkBank("R6 bank partial");
      base = nStr;
      senLow(); sendWord(4'd5, 12'(n * 41 + 7)); senHigh();
      model[5] = 12'(n * 41 + 7);
      check(nStr - base == 1, "R6 fresh window", nStr - base, 1);
      checkBank("R6 bank fresh");
    end
    base = nStr;
    senLow(); sendBits(32'h0000_7FFF, 15); senHigh();
    check(nStr == base, "R6 15 bits only", nStr - base, 0);
    checkBank("R6 bank 15 bits");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule